// File: doc/BRIEF.md
# Binary Hit-or-Miss Window Matcher

This block takes a binary image as a raster stream, one 1-bit pixel per accepted cycle. For every pixel it forms the 3x3 neighbourhood around that pixel and emits one result bit. The result is 1 when every neighbour that is not marked "don't care" equals the value the pattern asks for at that spot. Two 1-bit line delays, each one image line long, keep the two rows above the incoming pixel. Positions outside the frame read as 0.

The pattern and its don't-care mask are nine bits each and are written through a small write port. Writes go to a pending copy. That copy becomes the working copy when the next frame starts, so one frame is always processed with one setting.

A frame begins with a pixel flagged as start-of-frame. After the last pixel of the frame, the block spends one line plus one cycle feeding zeros through its own pipeline. During that time it holds `in_ready` low. This lets the bottom row and the last pixel's right neighbour resolve as padding.

Top module: `hm_morph`

## Requirements
- R1: After reset `out_valid` and `out_sof` are 0 and `in_ready` is 1. The working pattern is all ones and the working mask is all zeros.
- R2: The window is packed row-major: bit 8 is the upper-left neighbour, bit 4 is the centre and bit 0 is the lower-right neighbour. Pattern and mask use the same packing. An unmasked position matches only when the pixel equals the pattern bit, and a 0 in the pattern requires a 0 pixel.
- R3: A mask bit of 1 excludes that position. The result at that pixel does not depend on the pixel value there.
- R4: With the mask all ones, every output pixel is 1.
- R5: Neighbours above the first row, below the last row, left of column 0 and right of the last column read as 0.
- R6: With the pattern all ones and the mask all zeros, the output is the 3x3 binary erosion of the frame.
- R7: Each frame yields exactly IMG_W*IMG_H results in raster order. `out_sof` is 1 together with the first result only.
- R8: A write with `cfg_sel`=0 loads the pending pattern, and a write with `cfg_sel`=1 loads the pending mask. Pending values take effect at the next accepted start-of-frame pixel. A write during a frame does not change that frame's results.
- R9: After the last pixel of a frame, `in_ready` is 0 for exactly IMG_W+1 cycles. While no frame is open, pixels without `in_sof` are ignored and produce no results.
- R10: Idle cycles (`in_valid`=0) inside a frame do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_pix | input | 1 | Input pixel |
| in_ready | output | 1 | Block can take a pixel (low while flushing) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects pattern, 1 selects mask |
| cfg_data | input | 9 | Value written |
| out_valid | output | 1 | Result present |
| out_sof | output | 1 | Marks the first result of a frame |
| out_pix | output | 1 | Match result |

## Verification
The bench places single set pixels so that a swapped bit order or a mirrored window moves the hit to a different pixel. It runs all-ones frames, where a design that wraps row ends or reuses stale line contents instead of padding would set border results to 1. It writes a new pattern halfway through a frame, which exposes a design that applies settings at once by mixing two patterns in one frame. It also inserts gaps in the stream and offers pixels while no frame is open. A block that advances its counters on idle or stray input would shift or add results, and the bench counts the cycles of `in_ready` low to catch a flush of the wrong length.

// File: rtl/hm_pkg.sv
package hm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } hm_state_e;

    typedef struct packed {
        logic top;
        logic mid;
        logic bot;
    } hm_col_t;

    localparam int WIN_BITS = 9;

    // Pack three columns into the row-major window (bit 8 upper-left).
    function automatic logic [WIN_BITS-1:0] hm_pack(input hm_col_t lc, input hm_col_t cc, input hm_col_t rc);
        return {lc.top, cc.top, rc.top, lc.mid, cc.mid, rc.mid, lc.bot, cc.bot, rc.bot};
    endfunction

endpackage

// File: rtl/hm_linebuf.sv
module hm_linebuf #(
    parameter int IMG_W = 512
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         step,
    input  logic [$clog2(IMG_W)-1:0]     col_idx,
    input  logic                         pix_in,
    output logic                         tap_up1,
    output logic                         tap_up2
);
    localparam int NLINES = 2;

    logic [NLINES:0] taps;
    assign taps[0] = pix_in;

    // Cascade of one-bit delay lines, each one image line long.
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic mem [IMG_W];
        assign taps[g+1] = mem[col_idx];
        always_ff @(posedge clk) begin
            if (step) begin
                mem[col_idx] <= taps[g];
            end
        end
    end

    assign tap_up1 = taps[1];
    assign tap_up2 = taps[2];

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (int'(col_idx) < IMG_W)); // R7

endmodule

// File: rtl/hm_window.sv
module hm_window
    import hm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  hm_col_t              col_in,
    input  logic                 zero_left,
    input  logic                 zero_right,
    input  logic                 ctr_valid,
    input  logic                 ctr_sof,
    output logic [WIN_BITS-1:0]  win,
    output logic                 win_new,
    output logic                 win_sof
);
    typedef struct packed {
        hm_col_t c_left;
        hm_col_t c_mid;
        hm_col_t c_right;
        logic    zl;
        logic    zr;
        logic    nw;
        logic    sof;
    } win_s;

    win_s win_d, win_q;
    hm_col_t lc, rc;

    always_comb begin
        win_d     = win_q;
        win_d.nw  = 1'b0;
        win_d.sof = 1'b0;
        if (step) begin
            win_d.c_left  = win_q.c_mid;
            win_d.c_mid   = win_q.c_right;
            win_d.c_right = col_in;
            win_d.zl      = zero_left;
            win_d.zr      = zero_right;
            win_d.nw      = ctr_valid;
            win_d.sof     = ctr_sof;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    always_comb begin
        lc = win_q.zl ? '0 : win_q.c_left;
        rc = win_q.zr ? '0 : win_q.c_right;
    end

    assign win     = hm_pack(lc, win_q.c_mid, rc);
    assign win_new = win_q.nw;
    assign win_sof = win_q.sof;

endmodule

// File: rtl/hm_match.sv
module hm_match
    import hm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIN_BITS-1:0]  win,
    input  logic [WIN_BITS-1:0]  pattern,
    input  logic [WIN_BITS-1:0]  dontcare,
    input  logic                 win_new,
    input  logic                 win_sof,
    output logic                 res_pix,
    output logic                 res_valid,
    output logic                 res_sof
);
    typedef struct packed {
        logic pix;
        logic vld;
        logic sof;
    } res_s;

    res_s res_d, res_q;
    logic [WIN_BITS-1:0] eq_bits;
    logic [WIN_BITS-1:0] pass_bits;

    // First bank: per-point equality. Second bank: force excluded points to pass.
    for (genvar k = 0; k < WIN_BITS; k++) begin : g_cmp
        assign eq_bits[k]   = ~(win[k] ^ pattern[k]);
        assign pass_bits[k] = eq_bits[k] | dontcare[k];
    end

    always_comb begin
        res_d     = res_q;
        res_d.vld = win_new;
        res_d.sof = win_new & win_sof;
        if (win_new) begin
            res_d.pix = &pass_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_pix   = res_q.pix;
    assign res_valid = res_q.vld;
    assign res_sof   = res_q.sof;

    AST_SOF_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_sof |-> res_valid); // R7

    AST_FULL_MASK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && ($past(dontcare) == '1)) |-> res_pix); // R4

endmodule

// File: rtl/hm_morph.sv
module hm_morph
    import hm_pkg::*;
#(
    parameter int IMG_W = 512,
    parameter int IMG_H = 480
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_sof,
    input  logic                in_pix,
    output logic                in_ready,
    input  logic                cfg_we,
    input  logic                cfg_sel,
    input  logic [8:0]          cfg_data,
    output logic                out_valid,
    output logic                out_sof,
    output logic                out_pix
);
    localparam int CW = $clog2(IMG_W);
    localparam int RW = $clog2(IMG_H + 2);
    localparam logic [CW-1:0] LAST_COL  = CW'(IMG_W - 1);
    localparam logic [RW-1:0] LAST_ROW  = RW'(IMG_H - 1);
    localparam logic [RW-1:0] PAD_ROW   = RW'(IMG_H + 1);
    localparam logic [WIN_BITS-1:0] PAT_RST = '1;
    localparam logic [WIN_BITS-1:0] MSK_RST = '0;

    typedef struct packed {
        hm_state_e           st;
        logic [RW-1:0]       row;
        logic [CW-1:0]       col;
        logic [WIN_BITS-1:0] pat_pend;
        logic [WIN_BITS-1:0] msk_pend;
        logic [WIN_BITS-1:0] pat_act;
        logic [WIN_BITS-1:0] msk_act;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic          acc;
    logic          step;
    logic          frame_start;
    logic [RW-1:0] cur_row;
    logic [CW-1:0] cur_col;
    logic          tap_up1, tap_up2;
    hm_col_t       col_vec;
    logic          zl, zr, cvalid, csof;
    logic [WIN_BITS-1:0] win;
    logic          win_new, win_sof;

    assign in_ready    = (ctl_q.st != ST_FLUSH);
    assign acc         = in_valid && in_ready && ((ctl_q.st == ST_RUN) || in_sof);
    assign frame_start = acc && (ctl_q.st == ST_IDLE);
    assign step        = acc || (ctl_q.st == ST_FLUSH);
    assign cur_row     = (ctl_q.st == ST_IDLE) ? '0 : ctl_q.row;
    assign cur_col     = (ctl_q.st == ST_IDLE) ? '0 : ctl_q.col;

    // Column entering the window, with rows above the frame padded to 0.
    always_comb begin
        col_vec.bot = (ctl_q.st == ST_FLUSH) ? 1'b0 : in_pix;
        col_vec.mid = tap_up1 & (cur_row != '0);
        col_vec.top = tap_up2 & (cur_row >= RW'(2));
    end

    // Window centre sits one line and one pixel behind the arriving pixel.
    assign zr     = (cur_col == '0);
    assign zl     = (cur_col == CW'(1));
    assign cvalid = (cur_row >= RW'(2)) || ((cur_row == RW'(1)) && (cur_col != '0));
    assign csof   = (cur_row == RW'(1)) && (cur_col == CW'(1));

    always_comb begin
        ctl_d = ctl_q;
        if (step) begin
            if (cur_col == LAST_COL) begin
                ctl_d.col = '0;
                ctl_d.row = cur_row + RW'(1);
            end else begin
                ctl_d.col = cur_col + CW'(1);
                ctl_d.row = cur_row;
            end
        end
        unique case (ctl_q.st)
            ST_IDLE:  if (acc) ctl_d.st = ST_RUN;
            ST_RUN:   if (acc && (cur_row == LAST_ROW) && (cur_col == LAST_COL)) ctl_d.st = ST_FLUSH;
            ST_FLUSH: if (cur_row == PAD_ROW) ctl_d.st = ST_IDLE;
            default:  ctl_d.st = ST_IDLE;
        endcase
        if (frame_start) begin
            ctl_d.pat_act = ctl_q.pat_pend;
            ctl_d.msk_act = ctl_q.msk_pend;
        end
        if (cfg_we) begin
            if (cfg_sel) ctl_d.msk_pend = cfg_data;
            else         ctl_d.pat_pend = cfg_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.st       <= ST_IDLE;
            ctl_q.pat_pend <= PAT_RST;
            ctl_q.msk_pend <= MSK_RST;
            ctl_q.pat_act  <= PAT_RST;
            ctl_q.msk_act  <= MSK_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    hm_linebuf #(.IMG_W(IMG_W)) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .col_idx (cur_col),
        .pix_in  (col_vec.bot),
        .tap_up1 (tap_up1),
        .tap_up2 (tap_up2)
    );

    hm_window u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .col_in     (col_vec),
        .zero_left  (zl),
        .zero_right (zr),
        .ctr_valid  (cvalid),
        .ctr_sof    (csof),
        .win        (win),
        .win_new    (win_new),
        .win_sof    (win_sof)
    );

    hm_match u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .win       (win),
        .pattern   (ctl_q.pat_act),
        .dontcare  (ctl_q.msk_act),
        .win_new   (win_new),
        .win_sof   (win_sof),
        .res_pix   (out_pix),
        .res_valid (out_valid),
        .res_sof   (out_sof)
    );

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(ctl_q.pat_act) && $stable(ctl_q.msk_act))); // R8

    AST_NO_TAKE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_FLUSH) |-> !acc); // R9

    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |=> !out_sof); // R7

endmodule

// File: tb/hm_morph_tb.sv
`timescale 1ns/1ps
module hm_morph_tb;
    localparam int W    = 8;
    localparam int H    = 6;
    localparam int NPIX = W * H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_pix = 1'b0;
    logic in_ready;
    logic cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [8:0] cfg_data = '0;
    logic out_valid, out_sof, out_pix;

    int total = 0;
    int bad = 0;
    int ocount = 0;
    int sofidx = -1;
    int lowcnt = 0;
    bit done = 1'b0;
    logic got [NPIX];
    logic [8:0] act_t = 9'h1FF;
    logic [8:0] act_m = 9'h000;

    always #2.5 clk = ~clk;

    hm_morph #(.IMG_W(W), .IMG_H(H)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix), .in_ready(in_ready),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .out_valid(out_valid), .out_sof(out_sof), .out_pix(out_pix)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            if (ocount < NPIX) got[ocount] = out_pix;
            if (out_sof) sofidx = ocount;
            ocount = ocount + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic exp_px(input logic [NPIX-1:0] im, input int r, input int c,
                                    input logic [8:0] t, input logic [8:0] m);
        logic [8:0] w = '0;
        for (int dr = -1; dr <= 1; dr++) begin
            for (int dc = -1; dc <= 1; dc++) begin
                int rr = r + dr;
                int cc = c + dc;
                logic b = 1'b0;
                if (rr >= 0 && rr < H && cc >= 0 && cc < W) b = im[rr*W + cc];
                w[8 - ((dr+1)*3 + (dc+1))] = b;
            end
        end
        return &(~(w ^ t) | m);
    endfunction

    function automatic logic [NPIX-1:0] gen_img(input int seed);
        logic [NPIX-1:0] im;
        for (int i = 0; i < NPIX; i++) im[i] = (((i*i*seed) + i*3 + seed) % 5) < 3;
        return im;
    endfunction

    task automatic write_cfg(input logic sel, input logic [8:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_frame(input logic [NPIX-1:0] im, input int gap, input bit mid_wr,
                             input logic [8:0] wt, input logic [8:0] wm);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        ocount = 0; sofidx = -1; lowcnt = 0;
        for (int i = 0; i < NPIX; i++) begin
            in_valid = 1'b1; in_sof = (i == 0); in_pix = im[i];
            if (mid_wr && i == NPIX/2)     begin cfg_we = 1'b1; cfg_sel = 1'b0; cfg_data = wt; end
            if (mid_wr && i == NPIX/2 + 1) begin cfg_we = 1'b1; cfg_sel = 1'b1; cfg_data = wm; end
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b0; cfg_we = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
        for (int k = 0; k < W + 8; k++) begin
            if (!in_ready) lowcnt++;
            @(negedge clk);
        end
    endtask

    task automatic check_frame(input logic [NPIX-1:0] im, input logic [8:0] t,
                               input logic [8:0] m, input string req);
        chk(ocount == NPIX, "R7 result count", ocount, NPIX);
        chk(sofidx == 0, "R7 sof position", sofidx, 0);
        for (int i = 0; i < NPIX && i < ocount; i++) begin
            logic e = exp_px(im, i / W, i % W, t, m);
            chk(got[i] === e, req, int'(got[i]), int'(e));
        end
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(out_sof == 1'b0, "R1 out_sof", int'(out_sof), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    endtask

    task automatic t_erosion();
        logic [NPIX-1:0] im = gen_img(7);
        run_frame(im, 0, 1'b0, '0, '0);
        check_frame(im, 9'h1FF, 9'h000, "R6 default erosion");
        chk(lowcnt == W + 1, "R9 flush length", lowcnt, W + 1);
    endtask

    task automatic t_border();
        logic [NPIX-1:0] im = '1;
        int ones = 0;
        run_frame(im, 0, 1'b0, '0, '0);
        check_frame(im, act_t, act_m, "R5 zero padding");
        for (int i = 0; i < ocount && i < NPIX; i++) ones += int'(got[i]);
        chk(ones == (W-2)*(H-2), "R5 interior only", ones, (W-2)*(H-2));
        chk(got[0] === 1'b0 && got[NPIX-1] === 1'b0, "R5 corners", int'(got[NPIX-1]), 0);
    endtask

    task automatic t_pattern();
        logic [NPIX-1:0] im = gen_img(3);
        act_t = 9'b010_111_010; act_m = 9'h000;
        write_cfg(1'b0, act_t);
        run_frame(im, 0, 1'b0, '0, '0);
        check_frame(im, act_t, act_m, "R2 exact pattern");
    endtask

    task automatic t_bitorder();
        logic [NPIX-1:0] im = '0;
        int ones = 0;
        im[2*W + 3] = 1'b1;
        act_t = 9'h100; act_m = 9'h0FF;
        write_cfg(1'b0, act_t);
        write_cfg(1'b1, act_m);
        run_frame(im, 0, 1'b0, '0, '0);
        chk(got[3*W + 4] === 1'b1, "R2 upper-left is bit 8", int'(got[3*W+4]), 1);
        for (int i = 0; i < ocount && i < NPIX; i++) ones += int'(got[i]);
        chk(ones == 1, "R2 single hit", ones, 1);
    endtask

    task automatic t_mask();
        logic [NPIX-1:0] im = gen_img(11);
        act_t = 9'b101_010_101; act_m = 9'b100_000_001;
        write_cfg(1'b0, act_t);
        write_cfg(1'b1, act_m);
        run_frame(im, 0, 1'b0, '0, '0);
        check_frame(im, act_t, act_m, "R3 masked points");
        im = ~im;
        run_frame(im, 0, 1'b0, '0, '0);
        check_frame(im, act_t, act_m, "R3 masked points inverted");
    endtask

    task automatic t_mask_all();
        logic [NPIX-1:0] im = gen_img(5);
        int ones = 0;
        act_m = 9'h1FF;
        write_cfg(1'b1, act_m);
        run_frame(im, 0, 1'b0, '0, '0);
        for (int i = 0; i < ocount && i < NPIX; i++) ones += int'(got[i]);
        chk(ones == NPIX, "R4 all ones", ones, NPIX);
    endtask

    task automatic t_midframe();
        logic [NPIX-1:0] im = gen_img(9);
        logic [8:0] nt = 9'h1FF;
        logic [8:0] nm = 9'h000;
        run_frame(im, 0, 1'b1, nt, nm);
        check_frame(im, act_t, act_m, "R8 old setting kept");
        act_t = nt; act_m = nm;
        run_frame(im, 0, 1'b0, '0, '0);
        check_frame(im, act_t, act_m, "R8 new setting applied");
    endtask

    task automatic t_gaps();
        logic [NPIX-1:0] im = gen_img(13);
        run_frame(im, 2, 1'b0, '0, '0);
        check_frame(im, act_t, act_m, "R10 gaps");
    endtask

    task automatic t_ignore();
        logic [NPIX-1:0] im = gen_img(17);
        ocount = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_pix = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (W + 8) @(negedge clk);
        chk(ocount == 0, "R9 stray pixels ignored", ocount, 0);
        run_frame(im, 0, 1'b0, '0, '0);
        check_frame(im, act_t, act_m, "R9 frame after stray pixels");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_erosion();
        t_border();
        t_pattern();
        t_bitorder();
        t_mask();
        t_mask_all();
        t_midframe();
        t_gaps();
        t_ignore();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule